// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block turns single host requests into correctly ordered and correctly spaced DDR SDRAM commands. The host presents a one-hot command and a 22-bit address for one clock while the sequencer is idle. The sequencer then walks through its states and drives the row-strobe, column-strobe and write-enable code, the bank pins and the address pins. It also produces a refresh acknowledge, a read-data-valid window and a write-beat window. Data is modelled as one word per system clock, so each window lasts one cycle per burst beat.

Reads and writes always open the row with an activate command, wait the activate-to-column delay, and then issue a column command with auto-precharge. The block snoops burst length and CAS latency from each main mode-register load and uses them to place and size the read and write windows. A burst-stop request during a data window cuts the burst short. A burst-stop command then goes out on the next cycle.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is asserted, chip select is high, the {ras_n,cas_n,we_n} code is 111 (NOP) and ref_ack, rd_valid and wr_beat are low. After release the sequencer idles with chip select low and code 111.
- R2: The host command is one-hot on bits 7..1: 1 no-op, 2 mode load, 3 read, 4 write, 5 precharge-all, 6 refresh, 7 burst stop. It is taken only in the idle state. A zero or multi-hot value, a no-op, a burst stop while idle, or any command while busy leaves the outputs unchanged.
- R3: One cycle after a refresh is taken, code 001 is driven for exactly one cycle with ref_ack high in that same cycle.
- R4: One cycle after a precharge-all is taken, code 010 is driven for one cycle with address bit 10 set and all other address bits and the bank at 0.
- R5: One cycle after a mode load is taken, code 000 is driven with ddr_addr equal to host address bits 11..0. The bank is 01 when host address bit 20 is set (extended register) and 00 otherwise. Only loads with bit 20 clear update the snooped burst length and CAS latency.
- R6: For a read or write, host address bits 21..20 give the bank, bits 19..8 the row and bits 7..0 the column. One cycle after the request is taken, code 011 is driven with that bank and with the row on ddr_addr.
- R7: The column command follows the activate by TRCD cycles (default 2), with NOP in between. It is 101 for read and 100 for write, with the same bank, ddr_addr bit 10 set, the column on bits 7..0 and other bits 0.
- R8: rd_valid rises CL cycles after the read command and stays high for BL cycles, with NOP driven throughout. CL is 2 for code 010 and 3 for any other code (2.5 rounds up). BL is 4 for code 010, 8 for 011 and 2 otherwise. The codes sit at mode bits 6..4 and 2..0, and the values after reset are CL 2, BL 2.
- R9: wr_beat is high for BL cycles starting the cycle after the write command, with NOP driven throughout.
- R10: A burst stop sampled during a data-window cycle ends the window after that cycle. Code 110 is driven in the next cycle and the sequencer returns to idle. A burst stop outside a window has no effect.
- R11: Every cycle that issues no command drives code 111 with chip select low, bank 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cmd | input | 7 | One-hot host command, indexed 7..1 |
| host_addr | input | 22 | Host address: bank, row, column, or mode fields |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, command code bit 2 |
| ddr_cas_n | output | 1 | Column strobe, command code bit 1 |
| ddr_we_n | output | 1 | Write enable, command code bit 0 |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | 12 | Row, column or mode value |
| ref_ack | output | 1 | One-cycle refresh acknowledge |
| rd_valid | output | 1 | Read data window |
| wr_beat | output | 1 | Write data window |

## Verification
A state register that slips by one cycle moves the column command off its TRCD slot, or shifts rd_valid against the CAS latency. Either shows on the command pins within a few cycles of the request. A corrupted snooped mode field changes the length of the next window, which shows by its last beat. A missed idle return or a stale burst-stop flag shows as a non-NOP code or a dead host command in the following idle cycle. The bench compares every cycle's full pin set against a queued expectation, so each of these appears in the cycle it occurs.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REF, ST_PRE, ST_LMR, ST_ACT, ST_ACT_WAIT,
    ST_RD, ST_WR, ST_RD_WAIT, ST_RD_DATA, ST_WR_DATA
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_LMR, OP_RD, OP_WR, OP_PRE, OP_REF, OP_STOP
  } host_op_t;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] DC_LMR = 3'b000;
  localparam logic [2:0] DC_REF = 3'b001;
  localparam logic [2:0] DC_PRE = 3'b010;
  localparam logic [2:0] DC_ACT = 3'b011;
  localparam logic [2:0] DC_WRA = 3'b100;
  localparam logic [2:0] DC_RDA = 3'b101;
  localparam logic [2:0] DC_BST = 3'b110;
  localparam logic [2:0] DC_NOP = 3'b111;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import ddr_seq_pkg::*;
(
  input  logic [7:1] host_cmd,
  output host_op_t   op
);
  always_comb begin
    op = OP_NONE;
    if ($onehot(host_cmd)) begin
      if      (host_cmd[2]) op = OP_LMR;
      else if (host_cmd[3]) op = OP_RD;
      else if (host_cmd[4]) op = OP_WR;
      else if (host_cmd[5]) op = OP_PRE;
      else if (host_cmd[6]) op = OP_REF;
      else if (host_cmd[7]) op = OP_STOP;
    end
  end
endmodule

// File: rtl/seq_mode_snoop.sv
module seq_mode_snoop #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [2:0]       bl_code,
  input  logic [2:0]       cl_code,
  output logic [CNT_W-1:0] bl_cyc,
  output logic [CNT_W-1:0] cl_cyc
);
  logic [2:0] bl_q, cl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q <= 3'b001;
      cl_q <= 3'b010;
    end else if (capture) begin
      bl_q <= bl_code;
      cl_q <= cl_code;
    end
  end

  always_comb begin
    case (bl_q)
      3'b010:  bl_cyc = CNT_W'(4);
      3'b011:  bl_cyc = CNT_W'(8);
      default: bl_cyc = CNT_W'(2);
    endcase
    // half-cycle latency is rounded up to whole cycles
    if (cl_q == 3'b010) cl_cyc = CNT_W'(2);
    else                cl_cyc = CNT_W'(3);
  end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DA_W    = 12,
  parameter int ADDR_W  = BANK_W + ROW_W + COL_W,
  parameter int TRCD    = 2,
  parameter int CNT_W   = 4,
  parameter int AP_BIT  = 10,
  parameter int EXT_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:1]        host_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BANK_W-1:0] ddr_ba,
  output logic [DA_W-1:0]   ddr_addr,
  output logic              ref_ack,
  output logic              rd_valid,
  output logic              wr_beat
);
  localparam int ROW_LSB  = COL_W;
  localparam int BANK_LSB = COL_W + ROW_W;

  logic             rst_s_n;
  host_op_t         op;
  seq_state_t       st_q, st_d;
  logic             bst_q, bst_d;
  logic             wr_q;
  logic             cs_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic             take;
  logic             snoop;
  logic             tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] bl_cyc, cl_cyc;
  logic [2:0]       cmd_w;

  seq_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  seq_cmd_decode i_dec (.host_cmd(host_cmd), .op(op));

  seq_mode_snoop #(.CNT_W(CNT_W)) i_mode (
    .clk(clk), .rst_n(rst_s_n), .capture(snoop),
    .bl_code(host_addr[2:0]), .cl_code(host_addr[6:4]),
    .bl_cyc(bl_cyc), .cl_cyc(cl_cyc)
  );

  seq_wait_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    bst_d   = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    take    = 1'b0;
    snoop   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        take = (op != OP_NONE) && (op != OP_STOP);
        case (op)
          OP_LMR: begin st_d = ST_LMR; snoop = !host_addr[EXT_BIT]; end
          OP_REF: st_d = ST_REF;
          OP_PRE: st_d = ST_PRE;
          OP_RD, OP_WR: st_d = ST_ACT;
          default: st_d = ST_IDLE;
        endcase
      end
      ST_ACT: begin
        st_d    = ST_ACT_WAIT;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(TRCD - 2);
      end
      ST_ACT_WAIT: if (tmr_zero) st_d = wr_q ? ST_WR : ST_RD;
      ST_RD: begin
        st_d    = ST_RD_WAIT;
        tmr_ld  = 1'b1;
        tmr_val = cl_cyc - CNT_W'(2);
      end
      ST_RD_WAIT: if (tmr_zero) begin
        st_d    = ST_RD_DATA;
        tmr_ld  = 1'b1;
        tmr_val = bl_cyc - CNT_W'(1);
      end
      ST_WR: begin
        st_d    = ST_WR_DATA;
        tmr_ld  = 1'b1;
        tmr_val = bl_cyc - CNT_W'(1);
      end
      ST_RD_DATA, ST_WR_DATA: begin
        if (op == OP_STOP) begin
          st_d  = ST_IDLE;
          bst_d = 1'b1;
        end else if (tmr_zero) begin
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state and capture registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      bst_q  <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      bst_q  <= bst_d;
      cs_n_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (take) begin
      addr_q <= host_addr;
      wr_q   <= (op == OP_WR);
    end
  end

  // output decode
  always_comb begin
    cmd_w    = DC_NOP;
    ddr_ba   = '0;
    ddr_addr = '0;
    ref_ack  = 1'b0;
    rd_valid = 1'b0;
    wr_beat  = 1'b0;
    case (st_q)
      ST_IDLE: if (bst_q) cmd_w = DC_BST;
      ST_REF: begin cmd_w = DC_REF; ref_ack = 1'b1; end
      ST_PRE: begin cmd_w = DC_PRE; ddr_addr[AP_BIT] = 1'b1; end
      ST_LMR: begin
        cmd_w    = DC_LMR;
        ddr_ba   = addr_q[EXT_BIT] ? BANK_W'(1) : '0;
        ddr_addr = addr_q[DA_W-1:0];
      end
      ST_ACT: begin
        cmd_w    = DC_ACT;
        ddr_ba   = addr_q[BANK_LSB +: BANK_W];
        ddr_addr = addr_q[ROW_LSB +: ROW_W];
      end
      ST_RD, ST_WR: begin
        cmd_w                = (st_q == ST_WR) ? DC_WRA : DC_RDA;
        ddr_ba               = addr_q[BANK_LSB +: BANK_W];
        ddr_addr[COL_W-1:0]  = addr_q[COL_W-1:0];
        ddr_addr[AP_BIT]     = 1'b1;
      end
      ST_RD_DATA: rd_valid = 1'b1;
      ST_WR_DATA: wr_beat  = 1'b1;
      default: cmd_w = DC_NOP;
    endcase
  end

  assign ddr_cs_n  = cs_n_q;
  assign ddr_ras_n = cmd_w[2];
  assign ddr_cas_n = cmd_w[1];
  assign ddr_we_n  = cmd_w[0];

  // checks next to the logic they guard
  p_refack_single_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ref_ack |=> !ref_ack);
  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_w == DC_PRE) |-> ddr_addr[AP_BIT]);
  p_act_gap_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_w == DC_ACT) |=> (cmd_w == DC_NOP));
  p_col_ap_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_w == DC_RDA || cmd_w == DC_WRA) |-> ddr_addr[AP_BIT] && ($past(cmd_w) == DC_NOP));
  p_rd_lat_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rd_valid) |-> ($past(cmd_w) == DC_NOP));
  p_excl_win_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rd_valid && wr_beat));
  p_wr_start_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(wr_beat) |-> ($past(cmd_w) == DC_WRA));
  p_bst_src_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_w == DC_BST) |-> $past(rd_valid || wr_beat));
endmodule

// File: tb/test_ddr_cmd_seq.sv
`timescale 1ns/1ps
module test_ddr_cmd_seq;
  localparam int TRCD = 2;
  localparam logic [7:1] H_NOP = 7'b0000001, H_LMR = 7'b0000010, H_RD = 7'b0000100,
                         H_WR = 7'b0001000, H_PRE = 7'b0010000, H_REF = 7'b0100000,
                         H_BST = 7'b1000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  host_cmd = '0;
  logic [21:0] host_addr = '0;
  logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [1:0]  ddr_ba;
  logic [11:0] ddr_addr;
  logic        ref_ack, rd_valid, wr_beat;

  ddr_cmd_seq #(.TRCD(TRCD)) i_ddr_cmd_seq (
    .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .host_addr(host_addr),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .ref_ack(ref_ack), .rd_valid(rd_valid), .wr_beat(wr_beat)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] cmd; logic [1:0] ba; logic [11:0] addr;
    logic ra; logic rv; logic wb; string tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0, bad = 0;
  bit   mon_on = 1'b0, done = 1'b0;
  int   bl_m = 2, cl_m = 2;

  function automatic exp_t mk(logic [2:0] c, logic [1:0] b, logic [11:0] a,
                              logic ra, logic rv, logic wb, string t);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.ra = ra; e.rv = rv; e.wb = wb; e.tag = t;
    return e;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] pins();
    return {12'd0, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_addr, ref_ack, rd_valid, wr_beat};
  endfunction

  // monitor: one comparison per cycle, idle NOP when nothing is queued (R11)
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (sb.size() > 0) e = sb.pop_front();
      else               e = mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R11");
      check(e.tag, pins(), {12'd0, 1'b0, e.cmd, e.ba, e.addr, e.ra, e.rv, e.wb});
    end
  end

  // driver: builds the expected cycle list from the requirements, then drives
  task automatic run_op(input logic [7:1] c, input logic [21:0] a,
                        input logic [7:1] x, input int xat, input string tag);
    exp_t l[$];
    int   d0;
    int   blen;
    bit   has_win;
    has_win = 1'b0;
    d0 = 0;
    blen = bl_m;
    wait (sb.size() == 0);
    @(posedge clk); #1;
    l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R11"));
    if ($onehot(c)) begin
      if (c[6]) l.push_back(mk(3'b001, 2'b00, 12'h000, 1'b1, 1'b0, 1'b0, "R3"));
      else if (c[5]) l.push_back(mk(3'b010, 2'b00, 12'h400, 1'b0, 1'b0, 1'b0, "R4"));
      else if (c[2]) begin
        l.push_back(mk(3'b000, a[20] ? 2'b01 : 2'b00, a[11:0], 1'b0, 1'b0, 1'b0, "R5"));
        if (!a[20]) begin
          bl_m = (a[2:0] == 3'b010) ? 4 : (a[2:0] == 3'b011) ? 8 : 2;
          cl_m = (a[6:4] == 3'b010) ? 2 : 3;
        end
      end else if (c[3] || c[4]) begin
        l.push_back(mk(3'b011, a[21:20], a[19:8], 1'b0, 1'b0, 1'b0, "R6"));
        for (int i = 0; i < TRCD - 1; i++)
          l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R7"));
        l.push_back(mk(c[3] ? 3'b101 : 3'b100, a[21:20], {4'h4, a[7:0]}, 1'b0, 1'b0, 1'b0, "R7"));
        if (c[3])
          for (int i = 0; i < cl_m - 1; i++)
            l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R8"));
        d0 = l.size();
        has_win = 1'b1;
        for (int i = 0; i < blen; i++)
          l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, c[3], c[4], c[3] ? "R8" : "R9"));
      end
    end
    if (l.size() == 1) begin
      l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R2"));
      l.push_back(mk(3'b111, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R2"));
    end
    if (has_win && x == H_BST && xat >= d0 && xat < d0 + blen) begin
      while (l.size() > xat + 1) void'(l.pop_back());
      l.push_back(mk(3'b110, 2'b00, 12'h000, 1'b0, 1'b0, 1'b0, "R10"));
    end
    if (tag != "") foreach (l[i]) l[i].tag = tag;
    foreach (l[i]) sb.push_back(l[i]);
    host_cmd = c; host_addr = a;
    @(posedge clk); #1;
    host_cmd = '0;
    if (xat >= 2) begin
      repeat (xat - 1) @(posedge clk);
      #1 host_cmd = x;
      @(posedge clk); #1;
      host_cmd = '0;
    end
  endtask

  initial begin
    #12;
    check("R1", pins(), {12'd0, 1'b1, 3'b111, 2'b00, 12'h000, 3'b000});
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R1", pins(), {12'd0, 1'b0, 3'b111, 2'b00, 12'h000, 3'b000});
    mon_on = 1'b1;
    run_op(H_REF, 22'h0, '0, -1, "");
    run_op(H_PRE, 22'h3FFFFF, '0, -1, "");
    run_op(H_LMR, 22'h000022, '0, -1, "");                 // CL 2, BL 4
    run_op(H_RD,  {2'b10, 12'h5A3, 8'h3C}, '0, -1, "");
    run_op(H_WR,  {2'b01, 12'hABC, 8'hF0}, '0, -1, "");
    run_op(H_LMR, 22'h100063, '0, -1, "");                 // extended: no snoop
    run_op(H_RD,  {2'b11, 12'h001, 8'h01}, '0, -1, "");
    run_op(H_LMR, 22'h000063, '0, -1, "");                 // CL 2.5 -> 3, BL 8
    run_op(H_RD,  {2'b00, 12'hFFF, 8'hFF}, '0, -1, "");
    run_op(H_WR,  {2'b10, 12'h123, 8'h45}, H_BST, 1 + TRCD + 1 + 2, "");  // R10 mid-burst
    run_op(H_RD,  {2'b01, 12'h777, 8'h08}, H_BST, 1 + TRCD + 3, "");      // R10 first beat
    run_op(H_LMR, 22'h000011, '0, -1, "");                 // CL 3, BL 2
    run_op(H_WR,  {2'b00, 12'h0F0, 8'h0F}, H_BST, 2, "R10");              // outside window
    run_op(H_RD,  {2'b11, 12'h800, 8'h80}, H_REF, 1 + TRCD + 1, "R2");    // busy: ignored
    run_op(7'b0000000, 22'h0, '0, -1, "R2");
    run_op(7'b0001100, 22'h0, '0, -1, "R2");
    run_op(H_BST, 22'h0, '0, -1, "R2");
    run_op(H_NOP, 22'h0, '0, -1, "R2");
    run_op(H_REF, 22'h0, '0, -1, "");
    wait (sb.size() == 0);
    repeat (3) @(posedge clk);
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end
endmodule